// File: doc/BRIEF.md
# Vectored Dual-Output Interrupt Controller

This block gathers 64 level-sensitive interrupt sources and drives two request lines toward a processor: a normal request and a fast request. Software configures it through a word-addressed register bus. Each source has an enable bit, a type bit that sends it to the fast line, and a 4-bit priority. A 5-bit threshold gates the normal line by priority. Two vector registers report the lowest-numbered active source of each kind and acknowledge it as a side effect of the read.

Each source input is sampled into a pending register on every clock. A pending bit follows its input one cycle later. Software can overwrite either half of the pending vector for a single cycle, and an acknowledging read clears the chosen bit for one cycle. Both request outputs are registered from the pending, enable, type, priority and threshold state. A source that rises therefore shows on its request line two clock edges later. Read data is registered, and it changes only on a read strobe.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the threshold reads 0x1F, the control word, the enables, the types, the priorities and the pending bits are all zero, and both request outputs are low.
- R2: The control word (word 0) stores only bits 25, 24, 22, 21, 20, 19 and 18 of a write, and all other bits read as zero. While the stored bit 24 is one, bit 25 is cleared by writing a one to it and is left alone by writing a zero. While bit 24 is zero, bit 25 takes the written value.
- R3: The threshold (word 1) keeps the low 5 bits of a write and reads back zero-extended.
- R4: A write to word 2 sets the enable of the source numbered by data bits [5:0]. A write to word 3 clears that enable. Both words read as zero.
- R5: Words 4 and 5 read and write enables 63..32 and 31..0. Words 6 and 7 do the same for the type bits, where 1 means fast.
- R6: Word 15-k holds the priorities of sources 8k..8k+7 (word 8 covers 56..63). Source 8k+j uses bits [4j+3:4j].
- R7: The fast output is high in a cycle exactly when, one edge earlier, some source was pending, enabled and typed fast.
- R8: When the threshold is 0x1F, the normal output follows any pending, enabled, normal-typed source. Otherwise the normal output needs such a source whose priority is strictly greater than the threshold. The output has the same one-edge delay as the fast output.
- R9: A read of word 16 returns the lowest-numbered pending, enabled normal source in bits [21:16] and its priority in bits [3:0], and clears that pending bit for one cycle. With no such source the read returns 0xFFFFFFFF.
- R10: A read of word 17 returns the lowest-numbered pending, enabled fast source number in bits [5:0] and acknowledges it in the same way. With no such source the read returns 0xFFFFFFFF.
- R11: Words 18 and 19 return the raw pending halves (upper, lower). Words 22/23 return the pending, enabled and normal halves, and words 24/25 the pending, enabled and fast halves. Writes to all of these words change nothing.
- R12: A write to word 20 or 21 replaces the upper or lower pending half for one cycle. After that cycle the pending bits follow the source inputs again. Both words read as zero.
- R13: Word 0x40 reads as 4. Writes to byte offsets 0x100..0x2FC change nothing. Reads of unmapped words return zero.
- R14: A pending bit takes its source level at each clock edge, unless a forced write or an acknowledge applies in that cycle. Read data and acknowledges occur only when select is high and write is low, and the read data holds otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 64 | Level of each interrupt source |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [11:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| norm_req | output | 1 | Normal interrupt request |
| fast_req | output | 1 | Fast interrupt request |

## Verification
The two request lines are driven with sources of mixed type and enable. This separates fast routing from normal routing and shows that a disabled source that is pending raises neither line. The threshold is swept below, equal to and above the source priorities, and also set to 0x1F with an all-zero priority, which separates strict comparison from the bypass value. Two sources are held high while word 16 is read back to back. The alternating answers show that an acknowledge clears only the winner and that the source sets its bit again one cycle later. Forced pending writes are read in the very next cycle and again one cycle after that, which exposes the one-cycle life of a forced bit.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // word indices inside the register window
   localparam logic [31:0] WRD_CTRL      = 32'd0;
   localparam logic [31:0] WRD_THRESH    = 32'd1;
   localparam logic [31:0] WRD_EN_SET    = 32'd2;
   localparam logic [31:0] WRD_EN_CLR    = 32'd3;
   localparam logic [31:0] WRD_EN_HI     = 32'd4;
   localparam logic [31:0] WRD_EN_LO     = 32'd5;
   localparam logic [31:0] WRD_TYP_HI    = 32'd6;
   localparam logic [31:0] WRD_TYP_LO    = 32'd7;
   localparam int          PRIO_BASE     = 8;
   localparam logic [31:0] WRD_NVEC      = 32'd16;
   localparam logic [31:0] WRD_FVEC      = 32'd17;
   localparam logic [31:0] WRD_RAW_HI    = 32'd18;
   localparam logic [31:0] WRD_RAW_LO    = 32'd19;
   localparam logic [31:0] WRD_FRC_HI    = 32'd20;
   localparam logic [31:0] WRD_FRC_LO    = 32'd21;
   localparam logic [31:0] WRD_NPEND_HI  = 32'd22;
   localparam logic [31:0] WRD_NPEND_LO  = 32'd23;
   localparam logic [31:0] WRD_FPEND_HI  = 32'd24;
   localparam logic [31:0] WRD_FPEND_LO  = 32'd25;
   localparam logic [31:0] WRD_IDLE_VEC  = 32'd64;

   // control word layout
   localparam logic [31:0] CTRL_KEEP     = 32'h037C_0000;
   localparam int          CTRL_FLAG     = 25;
   localparam int          CTRL_FLAG_EN  = 24;

   localparam logic [31:0] IDLE_VEC_VAL  = 32'd4;
   localparam logic [31:0] NONE_VAL      = 32'hFFFF_FFFF;
   localparam int          VEC_IDX_LSB   = 16;

endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32,
   parameter int PRIO_W  = 4,
   parameter int MASK_W  = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [31:0]                      wr_word,
   input  logic [DATA_W-1:0]                wr_data,
   output logic [DATA_W-1:0]                ctrl_q,
   output logic [MASK_W-1:0]                thresh_q,
   output logic [NUM_SRC-1:0]               en_q,
   output logic [NUM_SRC-1:0]               typ_q,
   output logic [NUM_SRC-1:0][PRIO_W-1:0]   prio_q
);

   localparam int IDX_W      = $clog2(NUM_SRC);
   localparam int PER_WORD   = DATA_W / PRIO_W;
   localparam int PRIO_WORDS = NUM_SRC / PER_WORD;
   localparam int PRIO_TOP   = PRIO_BASE + PRIO_WORDS - 1;

   logic [DATA_W-1:0] ctrl_wv;

   always_comb begin
      ctrl_wv = wr_data & CTRL_KEEP;
      if (ctrl_q[CTRL_FLAG_EN]) begin
         ctrl_wv[CTRL_FLAG] = ctrl_q[CTRL_FLAG] & ~wr_data[CTRL_FLAG];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         thresh_q <= '1;
         en_q     <= '0;
         typ_q    <= '0;
      end else if (wr_en) begin
         case (wr_word)
            WRD_CTRL:   ctrl_q   <= ctrl_wv;
            WRD_THRESH: thresh_q <= wr_data[MASK_W-1:0];
            WRD_EN_SET: en_q[wr_data[IDX_W-1:0]] <= 1'b1;
            WRD_EN_CLR: en_q[wr_data[IDX_W-1:0]] <= 1'b0;
            WRD_EN_HI:  en_q[NUM_SRC-1:DATA_W]   <= wr_data;
            WRD_EN_LO:  en_q[DATA_W-1:0]         <= wr_data;
            WRD_TYP_HI: typ_q[NUM_SRC-1:DATA_W]  <= wr_data;
            WRD_TYP_LO: typ_q[DATA_W-1:0]        <= wr_data;
            default: ;
         endcase
      end
   end

   // priority storage: word PRIO_TOP-g holds group g, lower source in lower bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
      end else if (wr_en) begin
         for (int g = 0; g < PRIO_WORDS; g++) begin
            if (wr_word == 32'(PRIO_TOP - g)) begin
               for (int s = 0; s < PER_WORD; s++) begin
                  prio_q[g*PER_WORD + s] <= wr_data[s*PRIO_W +: PRIO_W];
               end
            end
         end
      end
   end

   AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_word == WRD_EN_SET) |=> en_q[$past(wr_data[IDX_W-1:0])]); // R4
   AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_word == WRD_EN_CLR) |=> !en_q[$past(wr_data[IDX_W-1:0])]); // R4
   AST_RO_NO_EN_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_word >= WRD_NVEC) |=> $stable(en_q) && $stable(typ_q) && $stable(thresh_q)); // R11

endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_SRC-1:0]           src_lvl,
   input  logic                         frc_hi,
   input  logic                         frc_lo,
   input  logic [DATA_W-1:0]            frc_data,
   input  logic                         ack_vld,
   input  logic [$clog2(NUM_SRC)-1:0]   ack_idx,
   output logic [NUM_SRC-1:0]           pend_q
);

   logic [NUM_SRC-1:0] pend_nxt;

   always_comb begin
      pend_nxt = src_lvl;
      if (frc_hi) pend_nxt[NUM_SRC-1:DATA_W] = frc_data;
      if (frc_lo) pend_nxt[DATA_W-1:0]       = frc_data;
      if (ack_vld) pend_nxt[ack_idx]         = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= pend_nxt;
   end

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |=> !pend_q[$past(ack_idx)]); // R9
   AST_FOLLOW_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (!frc_hi && !frc_lo && !ack_vld) |=> pend_q == $past(src_lvl)); // R14
   AST_FRC_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (frc_lo && !ack_vld) |=> pend_q[DATA_W-1:0] == $past(frc_data)); // R12

endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int NUM_SRC = 64,
   parameter int PRIO_W  = 4,
   parameter int MASK_W  = 5,
   parameter bit THRESH  = 1'b1
) (
   input  logic [NUM_SRC-1:0]               cand,
   input  logic [NUM_SRC-1:0][PRIO_W-1:0]   prio,
   input  logic [MASK_W-1:0]                mask,
   output logic                             found,
   output logic [$clog2(NUM_SRC)-1:0]       idx,
   output logic [PRIO_W-1:0]                idx_prio,
   output logic                             req_nxt
);

   localparam int IDX_W = $clog2(NUM_SRC);

   // lowest-numbered candidate wins
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (cand[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

   assign idx_prio = prio[idx];

   if (THRESH) begin : g_thresh
      logic [NUM_SRC-1:0] above;
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_cmp
         assign above[i] = MASK_W'(prio[i]) > mask;
      end
      assign req_nxt = (&mask) ? (|cand) : (|(cand & above));
   end else begin : g_plain
      logic mask_unused;
      assign mask_unused = ^mask;
      assign req_nxt     = |cand;
   end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
   import irqc_pkg::*;
#(
   parameter int NUM_SRC = 64,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 12,
   parameter int PRIO_W  = 4,
   parameter int MASK_W  = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   src_lvl,
   input  logic                 bus_sel,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 norm_req,
   output logic                 fast_req
);

   localparam int IDX_W      = $clog2(NUM_SRC);
   localparam int WORD_W     = ADDR_W - 2;
   localparam int PER_WORD   = DATA_W / PRIO_W;
   localparam int PRIO_WORDS = NUM_SRC / PER_WORD;
   localparam int PRIO_TOP   = PRIO_BASE + PRIO_WORDS - 1;

   if (DATA_W != 32) begin : g_chk_data
      $error("DATA_W must be 32");
   end
   if (NUM_SRC != 2 * DATA_W) begin : g_chk_src
      $error("NUM_SRC must be twice DATA_W");
   end
   if (DATA_W % PRIO_W != 0 || PRIO_TOP >= 16) begin : g_chk_prio
      $error("priority fields must pack into words 8..15");
   end
   if (MASK_W <= PRIO_W) begin : g_chk_mask
      $error("MASK_W must exceed PRIO_W");
   end
   if (ADDR_W < 10 || ADDR_W > 32) begin : g_chk_addr
      $error("ADDR_W out of range");
   end

   logic        rd_stb, wr_stb;
   logic [31:0] word;

   assign rd_stb = bus_sel & ~bus_wr;
   assign wr_stb = bus_sel &  bus_wr;
   assign word   = {{(32-WORD_W){1'b0}}, bus_addr[ADDR_W-1:2]};

   logic [DATA_W-1:0]             ctrl_q;
   logic [MASK_W-1:0]             thresh_q;
   logic [NUM_SRC-1:0]            en_q, typ_q, pend_q;
   logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;

   irqc_regs #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .PRIO_W  (PRIO_W),
      .MASK_W  (MASK_W)
   ) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_stb),
      .wr_word  (word),
      .wr_data  (bus_wdata),
      .ctrl_q   (ctrl_q),
      .thresh_q (thresh_q),
      .en_q     (en_q),
      .typ_q    (typ_q),
      .prio_q   (prio_q)
   );

   logic [NUM_SRC-1:0] n_cand, f_cand;
   assign n_cand = pend_q & en_q & ~typ_q;
   assign f_cand = pend_q & en_q &  typ_q;

   logic              n_found, f_found, n_req_nxt, f_req_nxt;
   logic [IDX_W-1:0]  n_idx, f_idx;
   logic [PRIO_W-1:0] n_prio, f_prio_unused;

   irqc_pick #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .MASK_W  (MASK_W),
      .THRESH  (1'b1)
   ) i_pick_norm (
      .cand     (n_cand),
      .prio     (prio_q),
      .mask     (thresh_q),
      .found    (n_found),
      .idx      (n_idx),
      .idx_prio (n_prio),
      .req_nxt  (n_req_nxt)
   );

   irqc_pick #(
      .NUM_SRC (NUM_SRC),
      .PRIO_W  (PRIO_W),
      .MASK_W  (MASK_W),
      .THRESH  (1'b0)
   ) i_pick_fast (
      .cand     (f_cand),
      .prio     (prio_q),
      .mask     (thresh_q),
      .found    (f_found),
      .idx      (f_idx),
      .idx_prio (f_prio_unused),
      .req_nxt  (f_req_nxt)
   );

   // acknowledge on vector reads
   logic             ack_vld;
   logic [IDX_W-1:0] ack_idx;

   always_comb begin
      ack_vld = 1'b0;
      ack_idx = n_idx;
      if (rd_stb && word == WRD_NVEC && n_found) begin
         ack_vld = 1'b1;
      end else if (rd_stb && word == WRD_FVEC && f_found) begin
         ack_vld = 1'b1;
         ack_idx = f_idx;
      end
   end

   irqc_pend #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W)
   ) i_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_lvl  (src_lvl),
      .frc_hi   (wr_stb && word == WRD_FRC_HI),
      .frc_lo   (wr_stb && word == WRD_FRC_LO),
      .frc_data (bus_wdata),
      .ack_vld  (ack_vld),
      .ack_idx  (ack_idx),
      .pend_q   (pend_q)
   );

   // read data selection
   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      case (word)
         WRD_CTRL:     rd_val = ctrl_q;
         WRD_THRESH:   rd_val = DATA_W'(thresh_q);
         WRD_EN_HI:    rd_val = en_q[NUM_SRC-1:DATA_W];
         WRD_EN_LO:    rd_val = en_q[DATA_W-1:0];
         WRD_TYP_HI:   rd_val = typ_q[NUM_SRC-1:DATA_W];
         WRD_TYP_LO:   rd_val = typ_q[DATA_W-1:0];
         WRD_NVEC: begin
            if (n_found) begin
               rd_val[VEC_IDX_LSB +: IDX_W] = n_idx;
               rd_val[PRIO_W-1:0]           = n_prio;
            end else begin
               rd_val = NONE_VAL;
            end
         end
         WRD_FVEC:     rd_val = f_found ? DATA_W'(f_idx) : NONE_VAL;
         WRD_RAW_HI:   rd_val = pend_q[NUM_SRC-1:DATA_W];
         WRD_RAW_LO:   rd_val = pend_q[DATA_W-1:0];
         WRD_NPEND_HI: rd_val = n_cand[NUM_SRC-1:DATA_W];
         WRD_NPEND_LO: rd_val = n_cand[DATA_W-1:0];
         WRD_FPEND_HI: rd_val = f_cand[NUM_SRC-1:DATA_W];
         WRD_FPEND_LO: rd_val = f_cand[DATA_W-1:0];
         WRD_IDLE_VEC: rd_val = IDLE_VEC_VAL;
         default: begin
            for (int g = 0; g < PRIO_WORDS; g++) begin
               if (word == 32'(PRIO_TOP - g)) begin
                  for (int s = 0; s < PER_WORD; s++) begin
                     rd_val[s*PRIO_W +: PRIO_W] = prio_q[g*PER_WORD + s];
                  end
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         norm_req  <= 1'b0;
         fast_req  <= 1'b0;
      end else begin
         if (rd_stb) bus_rdata <= rd_val;
         norm_req <= n_req_nxt;
         fast_req <= f_req_nxt;
      end
   end

   AST_FAST_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      (|f_cand) |=> fast_req); // R7
   AST_FAST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(|f_cand) |=> !fast_req); // R7
   AST_NORM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !(|n_cand) |=> !norm_req); // R8
   AST_NORM_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      ((&thresh_q) && (|n_cand)) |=> norm_req); // R8
   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(bus_rdata)); // R14
   AST_ACK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |-> !ack_vld); // R14

endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        norm_req, fast_req;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   irq_vec_ctrl i_irq_vec_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_lvl   (src),
      .bus_sel   (sel),
      .bus_wr    (wr),
      .bus_addr  (addr),
      .bus_wdata (wdata),
      .bus_rdata (rdata),
      .norm_req  (norm_req),
      .fast_req  (fast_req)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // all bus tasks start and end at a falling edge
   task automatic wr_addr(input logic [11:0] a, input logic [31:0] d);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic wrw(input int w, input logic [31:0] d);
      wr_addr(12'(w * 4), d);
   endtask

   task automatic rd_addr(input logic [11:0] a, output logic [31:0] d);
      sel = 1'b1; wr = 1'b0; addr = a;
      @(negedge clk);
      sel = 1'b0;
      d = rdata;
   endtask

   task automatic rdw(input int w, output logic [31:0] d);
      rd_addr(12'(w * 4), d);
   endtask

   task automatic rd_chk(input int w, input logic [31:0] exp, input string req);
      logic [31:0] d;
      rdw(w, d);
      check(req, d, exp);
   endtask

   task automatic t_reset;
      check("R1 norm_req", 32'(norm_req), 0);
      check("R1 fast_req", 32'(fast_req), 0);
      rd_chk(1, 32'h1F, "R1 threshold");
      rd_chk(0, 0, "R1 control");
      rd_chk(4, 0, "R1 enables hi");
      rd_chk(5, 0, "R1 enables lo");
      rd_chk(7, 0, "R1 types lo");
      rd_chk(15, 0, "R1 priorities");
      rd_chk(19, 0, "R1 pending lo");
   endtask

   task automatic t_ctrl;
      wrw(0, 32'hFFFF_FFFF);
      rd_chk(0, 32'h037C_0000, "R2 kept bits");
      wrw(0, 32'h0300_0000);
      rd_chk(0, 32'h0100_0000, "R2 flag write-one-clear");
      wrw(0, 32'h0100_0000);
      rd_chk(0, 32'h0100_0000, "R2 flag zero write keeps");
      wrw(0, 32'h0);
      rd_chk(0, 32'h0, "R2 cleared");
   endtask

   task automatic t_mask;
      wrw(1, 32'hFFFF_FFE5);
      rd_chk(1, 32'h05, "R3 five bits");
      wrw(1, 32'h1F);
   endtask

   task automatic t_enable;
      wrw(2, 32'hFFFF_FFC5);
      rd_chk(5, 32'h20, "R4 set by low six bits");
      wrw(2, 32'd40);
      rd_chk(4, 32'h100, "R4 set upper source");
      wrw(3, 32'h45);
      rd_chk(5, 32'h0, "R4 clear by number");
      rd_chk(2, 32'h0, "R4 set word reads zero");
      rd_chk(3, 32'h0, "R4 clear word reads zero");
      wrw(3, 32'd40);
      rd_chk(4, 32'h0, "R4 clear upper source");
   endtask

   task automatic t_halves;
      wrw(4, 32'hA5A5_0000);
      wrw(5, 32'h1234_5678);
      wrw(6, 32'h0F0F_0F0F);
      wrw(7, 32'h8000_0001);
      rd_chk(4, 32'hA5A5_0000, "R5 enable hi");
      rd_chk(5, 32'h1234_5678, "R5 enable lo");
      rd_chk(6, 32'h0F0F_0F0F, "R5 type hi");
      rd_chk(7, 32'h8000_0001, "R5 type lo");
      wrw(4, 0); wrw(5, 0); wrw(6, 0); wrw(7, 0);
   endtask

   task automatic t_prio;
      wrw(15, 32'h7654_3210);
      wrw(8, 32'hFEDC_BA98);
      rd_chk(15, 32'h7654_3210, "R6 word for sources 0..7");
      rd_chk(8, 32'hFEDC_BA98, "R6 word for sources 56..63");
      // source 3 has priority 3 via word 15 nibble 3: check through vector read
      wrw(2, 3);
      wrw(21, 32'h8);
      rd_chk(16, 32'h0003_0003, "R6 nibble position seen by vector");
      wrw(3, 3);
      wrw(15, 0); wrw(8, 0);
   endtask

   task automatic t_fast;
      wrw(7, 32'h8);
      wrw(2, 3);
      src[3] = 1'b1;
      @(negedge clk);
      check("R14 fast after one edge", 32'(fast_req), 0);
      @(negedge clk);
      check("R7 fast after two edges", 32'(fast_req), 1);
      check("R7 normal stays low", 32'(norm_req), 0);
      rd_chk(17, 32'd3, "R10 fast vector");
      src[3] = 1'b0;
      repeat (3) @(negedge clk);
      check("R7 fast falls", 32'(fast_req), 0);
      rd_chk(17, 32'hFFFF_FFFF, "R10 no fast source");
      rd_chk(16, 32'hFFFF_FFFF, "R9 no normal source");
      repeat (3) @(negedge clk);
      check("R14 rdata held without strobe", rdata, 32'hFFFF_FFFF);
      wrw(3, 3);
      wrw(7, 0);
   endtask

   task automatic t_ack;
      wrw(14, 32'h0000_0700);
      wrw(13, 32'h000B_0000);
      wrw(2, 10);
      wrw(2, 20);
      src[10] = 1'b1;
      src[20] = 1'b1;
      repeat (2) @(negedge clk);
      rd_chk(16, 32'h000A_0007, "R9 lowest wins");
      rd_chk(16, 32'h0014_000B, "R9 ack cleared winner");
      rd_chk(16, 32'h000A_0007, "R9 source sets bit again");
   endtask

   task automatic t_thresh;
      repeat (3) @(negedge clk);
      check("R8 bypass threshold", 32'(norm_req), 1);
      wrw(1, 32'h0B);
      @(negedge clk);
      check("R8 equal priority blocked", 32'(norm_req), 0);
      wrw(1, 32'h0A);
      @(negedge clk);
      check("R8 greater priority passes", 32'(norm_req), 1);
      wrw(1, 32'h10);
      @(negedge clk);
      check("R8 threshold above all", 32'(norm_req), 0);
      wrw(1, 32'h1F);
      src[10] = 1'b0;
      src[20] = 1'b0;
      wrw(3, 10);
      wrw(3, 20);
      wrw(2, 30);
      src[30] = 1'b1;
      repeat (3) @(negedge clk);
      check("R8 bypass with zero priority", 32'(norm_req), 1);
      wrw(1, 32'h00);
      @(negedge clk);
      check("R8 zero not above zero", 32'(norm_req), 0);
      wrw(1, 32'h1F);
      src[30] = 1'b0;
      wrw(3, 30);
      wrw(14, 0);
      wrw(13, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_views;
      wrw(2, 3);
      wrw(2, 10);
      wrw(7, 32'h8);
      src[3] = 1'b1; src[10] = 1'b1; src[12] = 1'b1;
      repeat (2) @(negedge clk);
      rd_chk(19, 32'h0000_1408, "R11 raw lo");
      rd_chk(18, 32'h0, "R11 raw hi");
      rd_chk(23, 32'h0000_0400, "R11 normal lo");
      rd_chk(25, 32'h0000_0008, "R11 fast lo");
      rd_chk(22, 32'h0, "R11 normal hi");
      rd_chk(24, 32'h0, "R11 fast hi");
      wrw(19, 32'h0);
      rd_chk(19, 32'h0000_1408, "R11 raw write ignored");
      wrw(23, 32'hFFFF_FFFF);
      wrw(25, 32'hFFFF_FFFF);
      rd_chk(25, 32'h0000_0008, "R11 view write ignored");
      rd_chk(5, 32'h0000_0408, "R11 enables untouched");
      src = '0;
      wrw(3, 3); wrw(3, 10); wrw(7, 0);
      repeat (2) @(negedge clk);
   endtask

   task automatic t_force;
      wrw(2, 40);
      wrw(6, 32'h100);
      wrw(20, 32'h100);
      check("R12 fast not yet", 32'(fast_req), 0);
      @(negedge clk);
      check("R12 forced bit raises fast", 32'(fast_req), 1);
      @(negedge clk);
      check("R12 forced bit lasts one cycle", 32'(fast_req), 0);
      wrw(20, 32'h100);
      rd_chk(18, 32'h100, "R12 forced hi visible");
      rd_chk(18, 32'h0, "R12 forced hi gone");
      wrw(21, 32'h10);
      rd_chk(19, 32'h10, "R12 forced lo visible");
      rd_chk(20, 32'h0, "R12 force hi reads zero");
      rd_chk(21, 32'h0, "R12 force lo reads zero");
      wrw(3, 40);
      wrw(6, 0);
   endtask

   task automatic t_misc;
      logic [31:0] d;
      rd_addr(12'h100, d);
      check("R13 idle vector word", d, 32'd4);
      wr_addr(12'h104, 32'hFFFF_FFFF);
      wr_addr(12'h108, 32'hFFFF_FFFF);
      wr_addr(12'h2FC, 32'hFFFF_FFFF);
      wr_addr(12'h100, 32'hFFFF_FFFF);
      rd_chk(1, 32'h1F, "R13 threshold untouched");
      rd_chk(5, 32'h0, "R13 enables untouched");
      rd_chk(7, 32'h0, "R13 types untouched");
      rd_chk(0, 32'h0, "R13 control untouched");
      rd_chk(30, 32'h0, "R13 unmapped reads zero");
      rd_addr(12'h1FC, d);
      check("R13 vector range reads zero", d, 32'h0);
   endtask

   initial begin
      #(4 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_mask();
      t_enable();
      t_halves();
      t_prio();
      t_fast();
      t_ack();
      t_thresh();
      t_views();
      t_force();
      t_misc();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule